// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt output toward a processor. Each request is latched into a request register. A mask register can hold it back. A fixed-priority resolver, in which input 0 ranks highest, picks the winner. A request also loses to any input of equal or higher rank that is already in service. When the processor acknowledges, the winner moves from the request register into the in-service register and the block supplies an 8-bit vector.

A strap input decides the role of each copy, so several copies can be chained: one master and up to eight slaves, giving up to 64 request lines. The interrupt output of each slave drives one request input of the master. The master's slave-present bitmap marks those inputs. When the winning master input is one of them, the master does not supply a vector. Instead it drives that input number onto a shared 3-bit cascade bus. The slave whose identity matches that number then supplies the vector one cycle later, and every other slave ignores the acknowledge.

In-service bits are released either by an end-of-interrupt command or, when automatic release is enabled, at the end of the response cycle. A nested option in the master lets a slave input that is already in service raise a new interrupt, which is needed when a higher-ranked request arrives on that slave.

Top module: `casc_pic`

## Requirements
- R1: After reset, int_out, vec_valid and cas_oe are low, the mask register is all ones, and the request, in-service, vector-base, cascade and mode registers are zero.
- R2: Writes with wr_sel 0 load the vector base, 1 the cascade word, 2 the mode (bit 0 automatic release, bit 1 nested), 3 the mask, and 4 issues end-of-interrupt. Among eligible requests the lowest input number wins, and the vector is vector-base bits 7..3 followed by the 3-bit winning input number.
- R3: A request whose mask bit is 1, or one blocked by an in-service bit of the same or a lower input number, does not raise int_out. A request stays latched while masked and is served once unmasked.
- R4: A master acknowledge whose winning input has a 0 in the cascade word gives vec_valid high for exactly the one cycle after the edge that samples inta. cas_oe stays low, and int_out is low in that cycle.
- R5: A master acknowledge whose winning input has a 1 in the cascade word drives cas_oe high for one cycle, with cas_out set to the input number, and the master gives no vector.
- R6: A slave samples cas_in and cas_vin one cycle after the edge that samples inta. If cas_vin is high and cas_in equals its cascade word bits 2..0, it gives its vector in the following cycle. Otherwise it gives no vector and keeps its request and in-service registers unchanged.
- R7: On acceptance the winning in-service bit is set and its request bit is cleared, so a line that has dropped does not request again.
- R8: An end-of-interrupt command clears the lowest-numbered set in-service bit. With automatic release off, it is the only way to clear in-service bits.
- R9: With mode bit 0 set, the accepted in-service bit clears at the end of the response cycle, and no command is needed.
- R10: With mode bit 1 set in a master, an input that has a 1 in the cascade word and is already in service can be accepted again. Inputs with a 0 in the cascade word, and any input when mode bit 1 is clear, stay blocked.

Sequencer states: IDLE waits for an acknowledge. SNOOP (slave only) samples the cascade bus. VECTOR presents the vector for one cycle. CASCADE (master only) drives the cascade bus for one cycle. Transitions:
- IDLE to VECTOR: master, winner not slave-fed.
- IDLE to CASCADE: master, winner slave-fed.
- IDLE to SNOOP: slave, acknowledge seen.
- SNOOP to VECTOR: identity match with a pending winner.
- SNOOP to IDLE: no match.
- VECTOR to IDLE and CASCADE to IDLE: always.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | Role strap, 1 master, 0 slave |
| irq_in | input | 8 | Request lines, level, latched |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register or command select |
| wr_data | input | 8 | Write data |
| inta | input | 1 | Acknowledge, one-cycle pulse |
| int_out | output | 1 | Interrupt request out |
| vec_out | output | 8 | Vector, meaningful with vec_valid |
| vec_valid | output | 1 | Vector valid, one cycle |
| cas_in | input | 3 | Cascade bus sense |
| cas_vin | input | 1 | Cascade bus driven flag sense |
| cas_out | output | 3 | Cascade bus drive value |
| cas_oe | output | 1 | Cascade bus drive enable |

## Verification
The assertions rely on three things about the inputs: the role strap and the cascade word do not change while an acknowledge is in flight, inta is a single-cycle pulse given only while the block is idle, and only the master's cas_out and cas_oe reach the slaves. The bench writes every configuration word before it raises requests, and it spaces each acknowledge by several idle cycles. It wires one master to two slaves on master inputs 3 and 5. It sweeps every input on the master and on both slaves, every ordered pair of direct master inputs, and every single-bit mask.

// File: rtl/casc_pic_pkg.sv
package casc_pic_pkg;
    parameter int IRQ_N  = 8;
    parameter int VEC_W  = 8;
    localparam int IDX_W  = $clog2(IRQ_N);
    localparam int DATA_W = (VEC_W > IRQ_N) ? VEC_W : IRQ_N;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_BASE = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CASC = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MODE = 3'd2;
    localparam logic [SEL_W-1:0] SEL_MASK = 3'd3;
    localparam logic [SEL_W-1:0] SEL_EOI  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SNOOP,
        ST_VECTOR,
        ST_CASCADE
    } seq_state_t;
endpackage

// File: rtl/casc_pic_regs.sv
module casc_pic_regs
    import casc_pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [VEC_W-1:0]  vec_base,
    output logic [IRQ_N-1:0]  casc_word,
    output logic [IRQ_N-1:0]  irq_mask,
    output logic              auto_eoi,
    output logic              nest_en,
    output logic              eoi_cmd
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base  <= '0;
            casc_word <= '0;
            irq_mask  <= '1;
            auto_eoi  <= 1'b0;
            nest_en   <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_BASE: vec_base  <= wr_data[VEC_W-1:0];
                SEL_CASC: casc_word <= wr_data[IRQ_N-1:0];
                SEL_MODE: begin
                    auto_eoi <= wr_data[0];
                    nest_en  <= wr_data[1];
                end
                SEL_MASK: irq_mask  <= wr_data[IRQ_N-1:0];
                default:  ;
            endcase
        end
    end

    assign eoi_cmd = wr_en && (wr_sel == SEL_EOI);
endmodule

// File: rtl/casc_pic_resolver.sv
module casc_pic_resolver
    import casc_pic_pkg::*;
(
    input  logic [IRQ_N-1:0] pend,
    input  logic [IRQ_N-1:0] busy,
    input  logic [IRQ_N-1:0] reenter,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [IRQ_N-1:0] elig;
    logic             above;

    always_comb begin
        above = 1'b0;
        for (int i = 0; i < IRQ_N; i++) begin
            elig[i] = pend[i] && !above && (!busy[i] || reenter[i]);
            above   = above | busy[i];
        end
        hit = |elig;
        idx = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/casc_pic_seq.sv
module casc_pic_seq
    import casc_pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             inta,
    input  logic [IRQ_N-1:0] casc_word,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [IDX_W-1:0] cas_in,
    input  logic             cas_vin,
    output seq_state_t       state,
    output logic             take,
    output logic             release_go,
    output logic [IDX_W-1:0] held_idx,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic [IDX_W-1:0] cas_out,
    output logic             cas_oe
);
    seq_state_t       state_n;
    logic             id_match;
    logic             to_slave;

    assign id_match = cas_vin && (cas_in == casc_word[IDX_W-1:0]);
    assign to_slave = casc_word[win_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            held_idx <= '0;
        end else begin
            state <= state_n;
            if (take) held_idx <= win_idx;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (inta && is_master && win_valid)
                    state_n = to_slave ? ST_CASCADE : ST_VECTOR;
                else if (inta && !is_master)
                    state_n = ST_SNOOP;
            end
            ST_SNOOP:   state_n = (id_match && win_valid) ? ST_VECTOR : ST_IDLE;
            ST_VECTOR:  state_n = ST_IDLE;
            ST_CASCADE: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        take       = 1'b0;
        release_go = 1'b0;
        vec_valid  = 1'b0;
        vec_out    = '0;
        cas_oe     = 1'b0;
        cas_out    = '0;
        unique case (state)
            ST_IDLE:  take = inta && is_master && win_valid;
            ST_SNOOP: take = id_match && win_valid;
            ST_VECTOR: begin
                vec_valid  = 1'b1;
                vec_out    = {vec_base[VEC_W-1:IDX_W], held_idx};
                release_go = 1'b1;
            end
            ST_CASCADE: begin
                cas_oe     = 1'b1;
                cas_out    = held_idx;
                release_go = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/casc_pic.sv
module casc_pic
    import casc_pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic [IRQ_N-1:0]  irq_in,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inta,
    output logic              int_out,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid,
    input  logic [IDX_W-1:0]  cas_in,
    input  logic              cas_vin,
    output logic [IDX_W-1:0]  cas_out,
    output logic              cas_oe
);
    logic [VEC_W-1:0] vec_base;
    logic [IRQ_N-1:0] casc_word, irq_mask, irr, isr, nest_ok;
    logic [IRQ_N-1:0] take_mask, eoi_mask, rel_mask;
    logic             auto_eoi, nest_en, eoi_cmd;
    logic             win_valid, take, release_go, top_valid;
    logic [IDX_W-1:0] win_idx, held_idx, top_idx;
    seq_state_t       state;

    casc_pic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .vec_base(vec_base), .casc_word(casc_word),
        .irq_mask(irq_mask), .auto_eoi(auto_eoi), .nest_en(nest_en),
        .eoi_cmd(eoi_cmd)
    );

    assign nest_ok = (is_master && nest_en) ? casc_word : '0;

    casc_pic_resolver u_win (
        .pend(irr & ~irq_mask), .busy(isr), .reenter(nest_ok),
        .hit(win_valid), .idx(win_idx)
    );

    casc_pic_resolver u_eoi_pick (
        .pend(isr), .busy('0), .reenter('0),
        .hit(top_valid), .idx(top_idx)
    );

    casc_pic_seq u_seq (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .inta(inta),
        .casc_word(casc_word), .vec_base(vec_base), .win_valid(win_valid),
        .win_idx(win_idx), .cas_in(cas_in), .cas_vin(cas_vin),
        .state(state), .take(take), .release_go(release_go),
        .held_idx(held_idx), .vec_out(vec_out), .vec_valid(vec_valid),
        .cas_out(cas_out), .cas_oe(cas_oe)
    );

    assign take_mask = take ? (IRQ_N'(1) << win_idx) : '0;
    assign eoi_mask  = (eoi_cmd && top_valid) ? (IRQ_N'(1) << top_idx) : '0;
    assign rel_mask  = (release_go && auto_eoi) ? (IRQ_N'(1) << held_idx) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= (irr | irq_in) & ~take_mask;
            isr <= (isr & ~eoi_mask & ~rel_mask) | take_mask;
        end
    end

    assign int_out = (state == ST_IDLE) && win_valid;
endmodule

module casc_pic_chk
    import casc_pic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             is_master,
    input logic             int_out,
    input logic [VEC_W-1:0] vec_out,
    input logic             vec_valid,
    input logic [IDX_W-1:0] cas_out,
    input logic             cas_oe,
    input logic [IRQ_N-1:0] casc_word,
    input logic [IRQ_N-1:0] irq_mask,
    input logic [IRQ_N-1:0] irr,
    input logic [IRQ_N-1:0] isr
);
    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr & ~irq_mask) == '0) |-> !int_out);
    // R4
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && cas_oe));
    // R4
    vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // R4
    resp_int_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid || cas_oe) |-> !int_out);
    // R4
    own_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && vec_valid) |-> !casc_word[vec_out[IDX_W-1:0]]);
    // R5
    cas_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe |-> (is_master && casc_word[cas_out]));
    // R7
    vec_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> isr[vec_out[IDX_W-1:0]]);
    // R7
    cas_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe |-> isr[cas_out]);
endmodule

bind casc_pic casc_pic_chk u_casc_pic_chk (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .int_out(int_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .cas_out(cas_out),
    .cas_oe(cas_oe), .casc_word(casc_word), .irq_mask(irq_mask),
    .irr(irr), .isr(isr)
);

// File: tb/casc_pic_bench.sv
module casc_pic_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inta = 1'b0;
    logic       wr_en_m = 1'b0, wr_en_a = 1'b0, wr_en_b = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] ext_m = '0, irq_a = '0, irq_b = '0;

    logic       m_int, a_int, b_int;
    logic [7:0] m_vec, a_vec, b_vec;
    logic       m_vv, a_vv, b_vv;
    logic [2:0] m_cas, a_cas, b_cas;
    logic       m_cas_oe, a_cas_oe, b_cas_oe;
    logic [7:0] m_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int r_mint, r_src, r_vec, r_cas;

    always #10 clk = ~clk;

    assign m_irq = {ext_m[7:6], b_int, ext_m[4], a_int, ext_m[2:0]};

    casc_pic u_casc_pic (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1), .irq_in(m_irq),
        .wr_en(wr_en_m), .wr_sel(wr_sel), .wr_data(wr_data), .inta(inta),
        .int_out(m_int), .vec_out(m_vec), .vec_valid(m_vv),
        .cas_in(3'd0), .cas_vin(1'b0), .cas_out(m_cas), .cas_oe(m_cas_oe)
    );

    casc_pic u_slave_a (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .irq_in(irq_a),
        .wr_en(wr_en_a), .wr_sel(wr_sel), .wr_data(wr_data), .inta(inta),
        .int_out(a_int), .vec_out(a_vec), .vec_valid(a_vv),
        .cas_in(m_cas), .cas_vin(m_cas_oe), .cas_out(a_cas), .cas_oe(a_cas_oe)
    );

    casc_pic u_slave_b (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .irq_in(irq_b),
        .wr_en(wr_en_b), .wr_sel(wr_sel), .wr_data(wr_data), .inta(inta),
        .int_out(b_int), .vec_out(b_vec), .vec_valid(b_vv),
        .cas_in(m_cas), .cas_vin(m_cas_oe), .cas_out(b_cas), .cas_oe(b_cas_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int chip, input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_sel = sel; wr_data = d;
        wr_en_m = (chip == 0); wr_en_a = (chip == 1); wr_en_b = (chip == 2);
        @(negedge clk);
        wr_en_m = 1'b0; wr_en_a = 1'b0; wr_en_b = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // src: 0 none, 1 master, 2 slave A, 3 slave B, 9 more than one; cas 15 = not driven
    task automatic do_ack;
        int nv;
        @(negedge clk);
        inta = 1'b1; ext_m = '0; irq_a = '0; irq_b = '0;
        @(negedge clk);
        inta = 1'b0;
        r_mint = m_int; r_cas = m_cas_oe ? int'(m_cas) : 15;
        nv = 0; r_src = 0; r_vec = 0;
        if (m_vv) begin nv++; r_src = 1; r_vec = m_vec; end
        if (a_vv || b_vv) nv = nv + 4;
        @(negedge clk);
        if (m_vv) nv = nv + 4;
        if (m_cas_oe) r_cas = 99;
        if (a_vv) begin nv++; r_src = 2; r_vec = a_vec; end
        if (b_vv) begin nv++; r_src = 3; r_vec = b_vec; end
        if (nv > 1) r_src = 9;
        @(negedge clk);
    endtask

    task automatic expect_ack(input string req, input int src, input int vec, input int cas);
        do_ack();
        check({req, " int low in response"}, r_mint, 0);
        check({req, " source"}, r_src, src);
        check({req, " vector"}, r_vec, vec);
        check({req, " cascade"}, r_cas, cas);
    endtask

    initial begin
        int direct[6] = '{0, 1, 2, 4, 6, 7};
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 int", m_int, 0);
        check("R1 vec_valid", m_vv, 0);
        check("R1 cas_oe", m_cas_oe, 0);
        ext_m[0] = 1'b1;
        idle(3);
        check("R1 mask all set", m_int, 0);
        ext_m = '0;
        // R2 register map
        wr(0, 3'd0, 8'h40); wr(0, 3'd1, 8'h28); wr(0, 3'd2, 8'h00); wr(0, 3'd3, 8'h00);
        wr(1, 3'd0, 8'h80); wr(1, 3'd1, 8'h03); wr(1, 3'd3, 8'h00);
        wr(2, 3'd0, 8'hC0); wr(2, 3'd1, 8'h05); wr(2, 3'd3, 8'h00);
        // R3 masked request was kept pending
        check("R3 held request after unmask", m_int, 1);
        expect_ack("R3", 1, 8'h40, 15);
        wr(0, 3'd4, 0);

        // R2 R4 R7 direct master inputs
        foreach (direct[n]) begin
            ext_m[direct[n]] = 1'b1;
            idle(3);
            check("R2 int raised", m_int, 1);
            expect_ack("R4", 1, 8'h40 + direct[n], 15);
            check("R7 blocked while in service", m_int, 0);
            wr(0, 3'd4, 0);
            check("R7 request cleared", m_int, 0);
        end

        // R5 R6 every input on each slave
        for (int s = 0; s < 2; s++) begin
            for (int j = 0; j < 8; j++) begin
                if (s == 0) irq_a[j] = 1'b1; else irq_b[j] = 1'b1;
                idle(3);
                check("R5 int via slave", m_int, 1);
                expect_ack("R5 R6", s + 2, (s == 0 ? 8'h80 : 8'hC0) + j, s == 0 ? 3 : 5);
                wr(s + 1, 3'd4, 0);
                wr(0, 3'd4, 0);
                check("R7 slave path quiet", m_int, 0);
            end
        end

        // R6 non-matching slave ignores and keeps its request
        irq_a[0] = 1'b1; irq_b[0] = 1'b1;
        idle(3);
        expect_ack("R6 first slave", 2, 8'h80, 3);
        wr(1, 3'd4, 0); wr(0, 3'd4, 0);
        idle(2);
        check("R6 other slave still pending", m_int, 1);
        expect_ack("R6 other slave", 3, 8'hC0, 5);
        wr(2, 3'd4, 0); wr(0, 3'd4, 0);

        // R2 R3 priority over ordered pairs
        for (int a = 0; a < 6; a++) begin
            for (int b = a + 1; b < 6; b++) begin
                ext_m[direct[a]] = 1'b1; ext_m[direct[b]] = 1'b1;
                idle(3);
                expect_ack("R2 pair winner", 1, 8'h40 + direct[a], 15);
                check("R3 lower blocked by in-service", m_int, 0);
                wr(0, 3'd4, 0);
                check("R3 lower released", m_int, 1);
                expect_ack("R2 pair second", 1, 8'h40 + direct[b], 15);
                wr(0, 3'd4, 0);
            end
        end

        // R3 each mask bit
        foreach (direct[n]) begin
            wr(0, 3'd3, 8'(1 << direct[n]));
            ext_m[direct[n]] = 1'b1;
            idle(3);
            check("R3 masked quiet", m_int, 0);
            wr(0, 3'd3, 8'h00);
            check("R3 unmasked", m_int, 1);
            expect_ack("R3 unmasked", 1, 8'h40 + direct[n], 15);
            wr(0, 3'd4, 0);
        end

        // R8 EOI clears lowest-numbered in-service bit
        ext_m[4] = 1'b1; idle(3);
        expect_ack("R8 low", 1, 8'h44, 15);
        ext_m[1] = 1'b1; idle(3);
        check("R8 higher preempts", m_int, 1);
        expect_ack("R8 high", 1, 8'h41, 15);
        wr(0, 3'd4, 0);
        ext_m[6] = 1'b1; idle(3);
        check("R8 input 4 still in service", m_int, 0);
        wr(0, 3'd4, 0);
        check("R8 input 4 released", m_int, 1);
        expect_ack("R8 after", 1, 8'h46, 15);
        wr(0, 3'd4, 0);

        // R9 automatic release
        wr(0, 3'd2, 8'h01);
        ext_m[2] = 1'b1; idle(3);
        expect_ack("R9 first", 1, 8'h42, 15);
        ext_m[7] = 1'b1; idle(3);
        check("R9 no command needed", m_int, 1);
        expect_ack("R9 second", 1, 8'h47, 15);
        check("R9 idle after", m_int, 0);
        wr(1, 3'd2, 8'h01);
        irq_a[4] = 1'b1; idle(3);
        expect_ack("R9 slave", 2, 8'h84, 3);
        irq_a[6] = 1'b1; idle(3);
        check("R9 slave released", m_int, 1);
        expect_ack("R9 slave second", 2, 8'h86, 3);
        wr(0, 3'd2, 8'h00); wr(1, 3'd2, 8'h00);

        // R10 nested acceptance on a slave input
        wr(0, 3'd2, 8'h02);
        irq_a[2] = 1'b1; idle(3);
        expect_ack("R10 first", 2, 8'h82, 3);
        irq_a[1] = 1'b1; idle(3);
        check("R10 nested int", m_int, 1);
        expect_ack("R10 nested", 2, 8'h81, 3);
        wr(1, 3'd4, 0); wr(1, 3'd4, 0); wr(0, 3'd4, 0); wr(0, 3'd4, 0);
        check("R10 all released", m_int, 0);
        ext_m[0] = 1'b1; idle(3);
        expect_ack("R10 direct", 1, 8'h40, 15);
        ext_m[0] = 1'b1; idle(3);
        check("R10 direct input not nested", m_int, 0);
        wr(0, 3'd4, 0);
        expect_ack("R10 direct again", 1, 8'h40, 15);
        wr(0, 3'd4, 0);
        wr(0, 3'd2, 8'h00);
        irq_a[2] = 1'b1; idle(3);
        expect_ack("R10 plain first", 2, 8'h82, 3);
        irq_a[1] = 1'b1; idle(3);
        check("R10 no nesting when off", m_int, 0);
        wr(0, 3'd4, 0); idle(2);
        check("R10 served after release", m_int, 1);
        expect_ack("R10 plain second", 2, 8'h81, 3);
        wr(1, 3'd4, 0); wr(1, 3'd4, 0); wr(0, 3'd4, 0);
        check("R10 end quiet", m_int, 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule